// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register front end of a single descriptor-driven DMA channel. A 32-bit register port addresses one channel's 256-byte window and reaches the control/status word, the address of the next control block to fetch, a free debug word, and read-only copies of the six-word descriptor that the transfer engine has most recently loaded. Writes to the control/status word combine three kinds of action in one access: write-one-to-clear status flags, a masked field that is replaced by the written value, and a self-clearing reset.

The transfer engine that sits beside this block gets a one-cycle start pulse when software turns the channel's active bit on. It reports back three events: a descriptor finished, that descriptor asked for an interrupt, and the whole chain finished. The block turns these events into status flags and the channel interrupt line. It also moves the control-block address on to the finished descriptor's link word. Reads are combinational. Every state change takes effect at the clock edge that samples the write or the event, and the start and acknowledge pulses are registered one cycle later.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous reset, the status word, control-block address, debug word and descriptor copies all read zero, and the interrupt, start and acknowledge outputs are low.
- R2: A write to offset 0x00 with bit 1 (end flag) set clears the end flag and leaves the interrupt flag (bit 2) unchanged.
- R3: A write to offset 0x00 with bit 2 set clears the interrupt flag and drops `chan_irq` at that edge. It also raises `irq_ack` for the following cycle, which clears this channel's bit in the global interrupt status.
- R4: Every write to offset 0x00 replaces the status bits under mask 0x30FF0001 with the written bits. Bits outside the mask are never taken from the written data.
- R5: A write to offset 0x00 with bit 31 set first clears the whole status word and the control-block address, and then applies the masked replacement of R4 from the same write.
- R6: `start_pulse` is high for exactly the one cycle after a status write that takes the active bit (bit 0) from 0 to 1. A write that finds the active bit already set gives no pulse.
- R7: An end-of-descriptor event sets the end flag and loads the control-block address from descriptor word 5 (the link). When the event is qualified as interrupting, it also sets the interrupt flag and raises `chan_irq`.
- R8: A chain-done event clears the active bit and sets the paused bit (bit 4).
- R9: Offset 0x04 (control-block address) and offset 0x20 (debug) read back what was written. Offsets 0x08 to 0x1C read descriptor words 0 to 5 in order (info, source, destination, length, stride, link). Only a descriptor load changes these words; bus writes to them have no effect.
- R10: A read of an offset above 0x20 or one that is not word aligned returns zero, and a write to such an offset changes nothing.
- R11: Bits 30 (abort) and 31 (reset) always read zero, and an abort write changes no state other than what R4 prescribes.
- R12: When an engine event arrives in the same cycle as a status write, the engine's settings win: a flag cleared by the write but set by the event ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read enable; read data is zero when low |
| bus_addr | input | AW | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| desc_load | input | 1 | Engine loads a new descriptor copy |
| desc_words | input | 192 | Six descriptor words, word k at bits [32k+31:32k] |
| eng_blk_end | input | 1 | Current descriptor finished |
| eng_blk_irq | input | 1 | Finished descriptor requests an interrupt |
| eng_chain_done | input | 1 | Descriptor chain finished |
| cb_addr_o | output | 32 | Current control-block address for the engine |
| start_pulse | output | 1 | One-cycle start request to the engine |
| irq_ack | output | 1 | One-cycle clear of the global interrupt status bit |
| chan_irq | output | 1 | Channel interrupt line |

## Verification
The embedded properties check the following on every cycle: a start pulse is never seen while the active bit was already set, the interrupt line only falls after a clearing or resetting status write, and the end and paused flags take hold at the edge after their engine events. They also check that descriptor copies never move without a load. Whether the masked field, the reset ordering, unmapped offsets and the engine-wins collision rule produce the right values can only be shown by the bench's scenarios. There, a behavioural model tracks the status word and address on every clock, and directed reads compare each offset against expected values.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_DESC = 6;
    localparam int DIDX_W   = $clog2(NUM_DESC);
    localparam int LINK_IDX = NUM_DESC - 1;

    // status word bit positions (software depends on them)
    localparam int B_ACTIVE = 0;
    localparam int B_END    = 1;
    localparam int B_INTR   = 2;
    localparam int B_PAUSED = 4;
    localparam int B_HELD   = 5;
    localparam int B_ERROR  = 8;
    localparam int B_ABORT  = 30;
    localparam int B_RESET  = 31;

    localparam logic [WORD_W-1:0] RW_MASK = 32'h30FF_0001;

    // word indices inside the window
    localparam int W_STATUS = 0;
    localparam int W_CBADDR = 1;
    localparam int W_DESC0  = 2;
    localparam int W_DEBUG  = W_DESC0 + NUM_DESC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CBADDR,
        SEL_DESC,
        SEL_DEBUG
    } reg_sel_e;

    typedef struct packed {
        logic blk_end;
        logic blk_irq;
        logic chain_done;
    } eng_evt_t;

    // applies one status write: reset first, then clears, then masked replace
    function automatic logic [WORD_W-1:0] status_after_write(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wd
    );
        logic [WORD_W-1:0] r;
        r = cur;
        if (wd[B_RESET]) r = '0;
        if (wd[B_END])   r[B_END]  = 1'b0;
        if (wd[B_INTR])  r[B_INTR] = 1'b0;
        r = (r & ~RW_MASK) | (wd & RW_MASK);
        return r;
    endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0]     addr,
    output reg_sel_e          sel,
    output logic [DIDX_W-1:0] desc_idx
);
    localparam int WA_W = AW - 2;

    logic [WA_W-1:0] word;
    logic            aligned;

    assign word    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel      = SEL_NONE;
        desc_idx = '0;
        if (aligned) begin
            if (word == WA_W'(W_STATUS)) begin
                sel = SEL_STATUS;
            end else if (word == WA_W'(W_CBADDR)) begin
                sel = SEL_CBADDR;
            end else if (word >= WA_W'(W_DESC0) && word < WA_W'(W_DEBUG)) begin
                sel      = SEL_DESC;
                desc_idx = DIDX_W'(word - WA_W'(W_DESC0));
            end else if (word == WA_W'(W_DEBUG)) begin
                sel = SEL_DEBUG;
            end
        end
    end

endmodule

// File: rtl/dma_csr_desc.sv
module dma_csr_desc
    import dma_csr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [NUM_DESC*WORD_W-1:0] words_in,
    output logic [WORD_W-1:0]          words_q [NUM_DESC]
);

    for (genvar k = 0; k < NUM_DESC; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[k] <= '0;
            end else if (load) begin
                words_q[k] <= words_in[k*WORD_W +: WORD_W];
            end
        end

        // R9: a copy only moves when the engine loads a descriptor
        assert_desc_hold_R9: assert property (@(posedge clk) disable iff (rst)
            !$past(load) |-> $stable(words_q[k]));
    end

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_status,
    input  logic              wr_cbaddr,
    input  logic [WORD_W-1:0] wdata,
    input  eng_evt_t          evt,
    input  logic [WORD_W-1:0] link_ptr,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] cbaddr_q,
    output logic              start_q,
    output logic              ack_q,
    output logic              irq
);

    logic [WORD_W-1:0] status_n;
    logic [WORD_W-1:0] cbaddr_n;
    logic              start_n;
    logic              ack_n;

    always_comb begin
        status_n = status_q;
        cbaddr_n = cbaddr_q;
        start_n  = 1'b0;
        ack_n    = 1'b0;

        if (wr_status) begin
            status_n = status_after_write(status_q, wdata);
            if (wdata[B_RESET]) cbaddr_n = '0;
            start_n  = !status_q[B_ACTIVE] && wdata[B_ACTIVE];
            ack_n    = wdata[B_INTR];
        end else if (wr_cbaddr) begin
            cbaddr_n = wdata;
        end

        // engine events are applied last so they win a collision
        if (evt.blk_end) begin
            status_n[B_END] = 1'b1;
            if (evt.blk_irq) status_n[B_INTR] = 1'b1;
            cbaddr_n = link_ptr;
        end
        if (evt.chain_done) begin
            status_n[B_ACTIVE] = 1'b0;
            status_n[B_PAUSED] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            cbaddr_q <= '0;
            start_q  <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            status_q <= status_n;
            cbaddr_q <= cbaddr_n;
            start_q  <= start_n;
            ack_q    <= ack_n;
        end
    end

    assign irq = status_q[B_INTR];

    assert_start_edge_R6: assert property (@(posedge clk) disable iff (rst)
        start_q |-> !$past(status_q[B_ACTIVE]));

    assert_irq_drop_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_status && (wdata[B_INTR] || wdata[B_RESET])));

    assert_end_set_R7: assert property (@(posedge clk) disable iff (rst)
        $past(evt.blk_end) |-> status_q[B_END]);

    assert_paused_R8: assert property (@(posedge clk) disable iff (rst)
        $past(evt.chain_done) |-> (status_q[B_PAUSED] && !status_q[B_ACTIVE]));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_csr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr_en,
    input  logic                       bus_rd_en,
    input  logic [AW-1:0]              bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic                       desc_load,
    input  logic [NUM_DESC*WORD_W-1:0] desc_words,
    input  logic                       eng_blk_end,
    input  logic                       eng_blk_irq,
    input  logic                       eng_chain_done,
    output logic [WORD_W-1:0]          cb_addr_o,
    output logic                       start_pulse,
    output logic                       irq_ack,
    output logic                       chan_irq
);

    reg_sel_e          sel;
    logic [DIDX_W-1:0] desc_idx;
    logic [WORD_W-1:0] desc_q [NUM_DESC];
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] cbaddr_q;
    logic [WORD_W-1:0] debug_q;
    eng_evt_t          evt;

    assign evt = '{blk_end: eng_blk_end, blk_irq: eng_blk_irq, chain_done: eng_chain_done};

    dma_csr_decode #(.AW(AW)) u_dec (
        .addr     (bus_addr),
        .sel      (sel),
        .desc_idx (desc_idx)
    );

    dma_csr_desc u_desc (
        .clk      (clk),
        .rst      (rst),
        .load     (desc_load),
        .words_in (desc_words),
        .words_q  (desc_q)
    );

    dma_csr_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .wr_status (bus_wr_en && sel == SEL_STATUS),
        .wr_cbaddr (bus_wr_en && sel == SEL_CBADDR),
        .wdata     (bus_wdata),
        .evt       (evt),
        .link_ptr  (desc_q[LINK_IDX]),
        .status_q  (status_q),
        .cbaddr_q  (cbaddr_q),
        .start_q   (start_pulse),
        .ack_q     (irq_ack),
        .irq       (chan_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            debug_q <= '0;
        end else if (bus_wr_en && sel == SEL_DEBUG) begin
            debug_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            unique case (sel)
                SEL_STATUS: bus_rdata = status_q;
                SEL_CBADDR: bus_rdata = cbaddr_q;
                SEL_DESC:   bus_rdata = (int'(desc_idx) < NUM_DESC) ? desc_q[desc_idx] : '0;
                SEL_DEBUG:  bus_rdata = debug_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign cb_addr_o = cbaddr_q;

endmodule

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr_en = 1'b0;
    logic         bus_rd_en = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         desc_load = 1'b0;
    logic [191:0] desc_words = '0;
    logic         eng_blk_end = 1'b0;
    logic         eng_blk_irq = 1'b0;
    logic         eng_chain_done = 1'b0;
    logic [31:0]  cb_addr_o;
    logic         start_pulse, irq_ack, chan_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_chan_regs u0 (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .desc_load(desc_load), .desc_words(desc_words),
        .eng_blk_end(eng_blk_end), .eng_blk_irq(eng_blk_irq),
        .eng_chain_done(eng_chain_done), .cb_addr_o(cb_addr_o),
        .start_pulse(start_pulse), .irq_ack(irq_ack), .chan_irq(chan_irq)
    );

    // behavioural reference model of the observable state
    logic [31:0] m_cs, m_cb, m_link, ncs, ncb;
    bit          m_start, m_ack;
    localparam logic [31:0] MASK = 32'h30FF0001;

    always @(posedge clk) begin
        if (rst) begin
            m_cs = 0; m_cb = 0; m_link = 0; m_start = 0; m_ack = 0;
        end else begin
            ncs = m_cs; ncb = m_cb;
            m_start = 0; m_ack = 0;
            if (bus_wr_en && bus_addr == 8'h00) begin
                if (bus_wdata[31]) begin ncs = 0; ncb = 0; end
                if (bus_wdata[1]) ncs[1] = 1'b0;
                if (bus_wdata[2]) ncs[2] = 1'b0;
                ncs = (ncs & ~MASK) | (bus_wdata & MASK);
                m_start = !m_cs[0] && bus_wdata[0];
                m_ack = bus_wdata[2];
            end
            if (bus_wr_en && bus_addr == 8'h04) ncb = bus_wdata;
            if (eng_blk_end) begin
                ncs[1] = 1'b1;
                if (eng_blk_irq) ncs[2] = 1'b1;
                ncb = m_link;
            end
            if (eng_chain_done) begin ncs[0] = 1'b0; ncs[4] = 1'b1; end
            if (desc_load) m_link = desc_words[191:160];
            m_cs = ncs; m_cb = ncb;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 model irq", {31'b0, chan_irq}, {31'b0, m_cs[2]});
            check("R3 model ack", {31'b0, irq_ack}, {31'b0, m_ack});
            check("R6 model start", {31'b0, start_pulse}, {31'b0, m_start});
            check("R7 model cb_addr", cb_addr_o, m_cb);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 0; bus_wdata = '0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        #1;
        bus_rd_en = 1; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_rd_en = 0;
    endtask

    task automatic pulse_evt(input bit e, input bit i, input bit c);
        @(negedge clk);
        eng_blk_end = e; eng_blk_irq = i; eng_chain_done = c;
        @(negedge clk);
        eng_blk_end = 0; eng_blk_irq = 0; eng_chain_done = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rdchk("R1 status", 8'h00, 32'h0);
        rdchk("R1 cbaddr", 8'h04, 32'h0);
        rdchk("R1 debug", 8'h20, 32'h0);
        rdchk("R1 desc0", 8'h08, 32'h0);
        check("R1 irq", {31'b0, chan_irq}, 32'h0);
        check("R1 start", {31'b0, start_pulse}, 32'h0);

        // R9 read-write words
        wr(8'h04, 32'h0000_1000);
        rdchk("R9 cbaddr", 8'h04, 32'h0000_1000);
        wr(8'h20, 32'hA5A5_5A5A);
        rdchk("R9 debug", 8'h20, 32'hA5A5_5A5A);
        wr(8'h0C, 32'hDEAD_BEEF);
        rdchk("R9 desc write ignored", 8'h0C, 32'h0);

        // R10 unmapped and misaligned
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_FFFF);
        rdchk("R10 read 0x24", 8'h24, 32'h0);
        rdchk("R10 read 0x22", 8'h22, 32'h0);
        rdchk("R10 debug untouched", 8'h20, 32'hA5A5_5A5A);
        rdchk("R10 cbaddr untouched", 8'h04, 32'h0000_1000);

        // R4 masked replace
        wr(8'h00, 32'h30FF_0000);
        rdchk("R4 mask bits set", 8'h00, 32'h30FF_0000);
        wr(8'h00, 32'h0F00_01F0);
        rdchk("R4 non-mask ignored", 8'h00, 32'h0);

        // R9 descriptor copies
        @(negedge clk);
        desc_load = 1;
        desc_words = {32'h0000_2000, 32'h0010_0020, 32'h0000_0040,
                      32'hB000_0000, 32'hA000_0000, 32'h0000_0101};
        @(negedge clk);
        desc_load = 0; desc_words = '0;
        rdchk("R9 info", 8'h08, 32'h0000_0101);
        rdchk("R9 source", 8'h0C, 32'hA000_0000);
        rdchk("R9 dest", 8'h10, 32'hB000_0000);
        rdchk("R9 length", 8'h14, 32'h0000_0040);
        rdchk("R9 stride", 8'h18, 32'h0010_0020);
        rdchk("R9 link", 8'h1C, 32'h0000_2000);

        // R6 start on rising active only
        wr(8'h00, 32'h0000_0001);
        check("R6 start pulse", {31'b0, start_pulse}, 32'h1);
        @(negedge clk);
        check("R6 one cycle", {31'b0, start_pulse}, 32'h0);
        wr(8'h00, 32'h0000_0001);
        check("R6 no restart", {31'b0, start_pulse}, 32'h0);

        // R7 descriptor end with interrupt
        pulse_evt(1, 1, 0);
        check("R7 irq raised", {31'b0, chan_irq}, 32'h1);
        check("R7 cb follows link", cb_addr_o, 32'h0000_2000);
        rdchk("R7 status", 8'h00, 32'h0000_0007);

        // R8 chain done
        pulse_evt(0, 0, 1);
        rdchk("R8 paused", 8'h00, 32'h0000_0016);

        // R2 clear end only
        wr(8'h00, 32'h0000_0002);
        rdchk("R2 end cleared", 8'h00, 32'h0000_0014);
        check("R2 irq kept", {31'b0, chan_irq}, 32'h1);

        // R3 clear interrupt
        wr(8'h00, 32'h0000_0004);
        check("R3 irq dropped", {31'b0, chan_irq}, 32'h0);
        check("R3 ack pulse", {31'b0, irq_ack}, 32'h1);
        rdchk("R3 status", 8'h00, 32'h0000_0010);

        // R11 abort has no effect, write-only bits read zero
        wr(8'h00, 32'h4000_0000);
        rdchk("R11 abort", 8'h00, 32'h0000_0010);
        check("R11 cb kept", cb_addr_o, 32'h0000_2000);

        // R5 reset
        wr(8'h00, 32'h8000_0000);
        rdchk("R5 status cleared", 8'h00, 32'h0);
        rdchk("R5 cbaddr cleared", 8'h04, 32'h0);

        // R12 collision: clear end while engine sets it
        pulse_evt(1, 0, 0);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = 8'h00; bus_wdata = 32'h0000_0002;
        eng_blk_end = 1;
        @(negedge clk);
        bus_wr_en = 0; bus_wdata = 0; eng_blk_end = 0;
        rdchk("R12 end stays set", 8'h00, 32'h0000_0002);

        // R5 with R6: reset plus active in one write
        wr(8'h00, 32'h8000_0001);
        check("R5 start after reset", {31'b0, start_pulse}, 32'h1);
        rdchk("R5 masked applied", 8'h00, 32'h0000_0001);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule